// File: doc/BRIEF.md
# Pressure-Ranked Wormhole Merge Switch

This block joins several request links onto a single link toward one memory target. Traffic arrives as packets made of cells. The first cell of a packet is its header, and a flag marks its final cell. Each link also carries a small priority sideband called pressure. When the output is free, the switch chooses one input. It then holds the path to that input until the final cell has gone out, so cells from different packets never mix on the output.

When several inputs compete, the input whose header shows the highest pressure wins. Inputs with equal pressure take turns in rotation. A header of the lock kind reserves the output for the input that sent it. Until that input finishes a write packet, no other input can get the output, which gives a master an atomic read-modify-write across several packets. Every link uses valid/ready flow control, and the switch holds one path through combinational steering, with no cell storage of its own. In the intended network, three first-stage links feed each instance.

Top module: `wsw_merge`

## Requirements
- R1: While reset is asserted, `out_valid` is low and every bit of `in_ready` is low, even if inputs present cells. No lock is held after reset.
- R2: Once an input is granted, all cells of its packet appear on the output in order, each exactly once, with `out_src` equal to that input. No other input's cell appears until the final cell has been transferred, and at most one `in_ready` bit is high at any time.
- R3: When the output is free, the winner is the requesting input with the highest pressure on its header cell.
- R4: Among requesting inputs that share the highest pressure, the winner is the first one found by counting upward, with wrap-around, from the input just after the previous winner. Input 0 follows input N-1.
- R5: `out_press` equals the header pressure for every cell of the packet. The pressure sideband on later cells has no effect, and an input that shows up with higher pressure in the middle of a packet does not take over the output.
- R6: While `out_ready` is low, the current grant is held, `out_valid` stays high, and `out_data` stays unchanged. No cell is lost or repeated.
- R7: The grant is released on the clock edge that transfers the final cell. On the next cycle `out_valid` is low while arbitration runs again.
- R8: The packet kind sits in bits [1:0] of the header cell: 0 read, 1 write, 2 lock, 3 non-posted write. Transferring a lock header reserves the output for the input that sent it. After that, only this owner can be granted.
- R9: The reservation ends when the final cell of a write (1) or non-posted write (3) packet from the owner is transferred. A read packet from the owner leaves the reservation in place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | N_IN | Cell present on each input |
| in_ready | output | N_IN | Cell accepted on each input |
| in_data | input | N_IN x DW | Cell payload per input; header bits [1:0] give the packet kind |
| in_last | input | N_IN | Final cell of the packet, per input |
| in_press | input | N_IN x PW | Pressure sideband per input |
| out_valid | output | 1 | Cell present on the output |
| out_ready | input | 1 | Output cell accepted downstream |
| out_data | output | DW | Output cell payload |
| out_last | output | 1 | Final cell of the output packet |
| out_press | output | PW | Pressure captured from the packet header |
| out_src | output | SW | Index of the input that owns the output |

## Verification
A wrong grant register shows up on the very next transferred cell: `out_src` changes in the middle of a packet, or cells from two inputs mix in the scoreboard order. A fault in the rotation pointer or the pressure comparison changes which packet comes out after the next idle cycle. A lock that is wrongly held or dropped has a delayed symptom. It only shows once a competing input with higher pressure is waiting: that input is then either served ahead of the owner's remaining packets or starved until the run's timeout.

// File: rtl/wsw_pkg.sv
package wsw_pkg;

  typedef enum logic [1:0] {
    PK_READ  = 2'd0,
    PK_WRITE = 2'd1,
    PK_LOCK  = 2'd2,
    PK_WRNP  = 2'd3
  } pkt_kind_e;

  function automatic logic kind_releases(input pkt_kind_e k);
    return (k == PK_WRITE) || (k == PK_WRNP);
  endfunction

endpackage

// File: rtl/wsw_arbiter.sv
module wsw_arbiter #(
  parameter int N  = 3,
  parameter int PW = 2,
  localparam int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         req,
  input  logic [N-1:0][PW-1:0] press,
  input  logic [SW-1:0]        prev,
  output logic                 win_valid,
  output logic [SW-1:0]        win_idx
);

  function automatic logic [PW-1:0] top_press(input logic [N-1:0] r,
                                              input logic [N-1:0][PW-1:0] p);
    logic [PW-1:0] m;
    m = '0;
    for (int i = 0; i < N; i++)
      if (r[i] && (p[i] > m)) m = p[i];
    return m;
  endfunction

  function automatic logic [SW-1:0] rot_pick(input logic [N-1:0] cand,
                                             input logic [SW-1:0] last);
    logic [SW-1:0] w;
    logic          got;
    int            j;
    w   = '0;
    got = 1'b0;
    for (int k = 1; k <= N; k++) begin
      j = (int'(last) + k) % N;
      if (!got && cand[j]) begin
        w   = SW'(j);
        got = 1'b1;
      end
    end
    return w;
  endfunction

  logic [PW-1:0] best;
  logic [N-1:0]  tied;

  always_comb begin
    best = top_press(req, press);
    for (int i = 0; i < N; i++)
      tied[i] = req[i] && (press[i] == best);
    win_valid = |req;
    win_idx   = rot_pick(tied, prev);
  end

  AST_WIN_REQUESTS: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> req[win_idx]);  // R3

  AST_WIN_TOP_PRESS: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (press[win_idx] >= press[prev] || !req[prev]));  // R3

endmodule

// File: rtl/wsw_grant.sv
module wsw_grant #(
  parameter int N  = 3,
  parameter int PW = 2,
  localparam int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          win_valid,
  input  logic [SW-1:0] win_idx,
  input  logic [PW-1:0] win_press,
  input  logic          cell_fire,
  input  logic          cell_last,
  output logic          busy,
  output logic          first,
  output logic [SW-1:0] gnt,
  output logic [SW-1:0] prev,
  output logic [PW-1:0] press_q
);

  logic take;
  logic done;

  assign take = !busy && win_valid;
  assign done = busy && cell_fire && cell_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      first   <= 1'b0;
      gnt     <= '0;
      prev    <= SW'(N - 1);
      press_q <= '0;
    end else if (take) begin
      busy    <= 1'b1;
      first   <= 1'b1;
      gnt     <= win_idx;
      prev    <= win_idx;
      press_q <= win_press;
    end else if (done) begin
      busy  <= 1'b0;
      first <= 1'b0;
    end else if (busy && cell_fire) begin
      first <= 1'b0;
    end
  end

  AST_HOLD_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy && $stable(gnt)));  // R2

  AST_PRESS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(press_q));  // R5

  AST_FREE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);  // R7

endmodule

// File: rtl/wsw_lock.sv
module wsw_lock #(
  parameter int N = 3,
  localparam int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hdr_fire,
  input  logic               last_fire,
  input  logic [SW-1:0]      src,
  input  wsw_pkg::pkt_kind_e kind,
  output logic               held,
  output logic [SW-1:0]      owner
);
  import wsw_pkg::*;

  logic rel_now;
  logic rel_pend;
  logic rel_eff;

  assign rel_now = held && (src == owner) && kind_releases(kind);
  assign rel_eff = hdr_fire ? rel_now : rel_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held     <= 1'b0;
      owner    <= '0;
      rel_pend <= 1'b0;
    end else begin
      if (hdr_fire && kind == PK_LOCK) begin
        held  <= 1'b1;
        owner <= src;
      end
      if (last_fire) begin
        rel_pend <= 1'b0;
        if (rel_eff) held <= 1'b0;
      end else if (hdr_fire) begin
        rel_pend <= rel_now;
      end
    end
  end

  AST_LOCK_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_fire && kind == PK_LOCK) |=> (held && owner == $past(src)));  // R8

  AST_READ_KEEPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (held && hdr_fire && kind == PK_READ && !last_fire) |=> held);  // R9

endmodule

// File: rtl/wsw_merge.sv
module wsw_merge #(
  parameter int N_IN = 3,
  parameter int DW   = 16,
  parameter int PW   = 2,
  localparam int SW  = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_IN-1:0]         in_valid,
  output logic [N_IN-1:0]         in_ready,
  input  logic [N_IN-1:0][DW-1:0] in_data,
  input  logic [N_IN-1:0]         in_last,
  input  logic [N_IN-1:0][PW-1:0] in_press,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [DW-1:0]           out_data,
  output logic                    out_last,
  output logic [PW-1:0]           out_press,
  output logic [SW-1:0]           out_src
);
  import wsw_pkg::*;

  logic            busy, first;
  logic [SW-1:0]   gnt, prev, owner;
  logic            held;
  logic [N_IN-1:0] eligible;
  logic            win_valid;
  logic [SW-1:0]   win_idx;
  logic [PW-1:0]   win_press;
  logic            out_fire;
  logic            hdr_fire;
  logic            last_fire;
  pkt_kind_e       kind;

  generate
    for (genvar g = 0; g < N_IN; g++) begin : g_port
      assign eligible[g] = !busy && in_valid[g] && (!held || owner == SW'(g));
      assign in_ready[g] = busy && (gnt == SW'(g)) && out_ready;
    end
  endgenerate

  assign win_press = in_press[win_idx];

  wsw_arbiter #(.N(N_IN), .PW(PW)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (eligible),
    .press     (in_press),
    .prev      (prev),
    .win_valid (win_valid),
    .win_idx   (win_idx)
  );

  wsw_grant #(.N(N_IN), .PW(PW)) u_gnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .win_press (win_press),
    .cell_fire (out_fire),
    .cell_last (out_last),
    .busy      (busy),
    .first     (first),
    .gnt       (gnt),
    .prev      (prev),
    .press_q   (out_press)
  );

  assign out_valid = busy && in_valid[gnt];
  assign out_data  = in_data[gnt];
  assign out_last  = in_last[gnt];
  assign out_src   = gnt;
  assign out_fire  = out_valid && out_ready;
  assign hdr_fire  = out_fire && first;
  assign last_fire = out_fire && out_last;
  assign kind      = pkt_kind_e'(out_data[1:0]);

  wsw_lock #(.N(N_IN)) u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .hdr_fire  (hdr_fire),
    .last_fire (last_fire),
    .src       (gnt),
    .kind      (kind),
    .held      (held),
    .owner     (owner)
  );

  AST_ONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_ready));  // R2

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && in_ready == '0));  // R1

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_src)));  // R6

  AST_GAP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    last_fire |=> !out_valid);  // R7

  AST_LOCK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (held && out_valid) |-> (out_src == owner));  // R8

endmodule

// File: tb/wsw_merge_bench.sv
module wsw_merge_bench;
  localparam int N  = 3;
  localparam int DW = 16;
  localparam int PW = 2;
  localparam int SW = 2;

  typedef struct packed {
    logic [DW-1:0] d;
    logic          l;
    logic [PW-1:0] p;
  } cell_t;

  typedef struct {
    logic [DW-1:0] d;
    logic          l;
    logic [PW-1:0] p;
    logic [SW-1:0] s;
    int            rq;
  } exp_t;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [N-1:0]         in_valid = '0;
  logic [N-1:0]         in_ready;
  logic [N-1:0][DW-1:0] in_data = '0;
  logic [N-1:0]         in_last = '0;
  logic [N-1:0][PW-1:0] in_press = '0;
  logic                 out_valid;
  logic                 out_ready = 1'b1;
  logic [DW-1:0]        out_data;
  logic                 out_last;
  logic [PW-1:0]        out_press;
  logic [SW-1:0]        out_src;

  int    errors = 0;
  int    checks = 0;
  int    cyc = 0;
  bit    stall_en = 1'b0;
  bit    gap_chk = 1'b0;
  bit    finished = 1'b0;
  cell_t iq0[$];
  cell_t iq1[$];
  cell_t iq2[$];
  exp_t  sb[$];

  always #4 clk = ~clk;

  wsw_merge #(.N_IN(N), .DW(DW), .PW(PW)) u_wsw_merge (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .in_press(in_press),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .out_press(out_press), .out_src(out_src)
  );

  // header bits [1:0] carry the packet kind (R8)
  function automatic logic [DW-1:0] mkdata(int src, int id, int idx, int typ);
    return {src[1:0], id[5:0], idx[5:0], typ[1:0]};
  endfunction

  task automatic add_pkt(int src, int id, int typ, int len, int hp, int bp);
    cell_t c;
    for (int i = 0; i < len; i++) begin
      c.d = mkdata(src, id, i, typ);
      c.l = (i == len - 1);
      c.p = (i == 0) ? hp[PW-1:0] : bp[PW-1:0];
      case (src)
        0: iq0.push_back(c);
        1: iq1.push_back(c);
        default: iq2.push_back(c);
      endcase
    end
  endtask

  task automatic exp_pkt(int src, int id, int typ, int len, int hp, int rq);
    exp_t e;
    for (int i = 0; i < len; i++) begin
      e.d = mkdata(src, id, i, typ);
      e.l = (i == len - 1);
      e.p = hp[PW-1:0];
      e.s = src[SW-1:0];
      e.rq = rq;
      sb.push_back(e);
    end
  endtask

  task automatic check(bit ok, int rq, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", rq, what, act, expv);
    end
  endtask

  task automatic drain();
    do @(posedge clk);
    while (sb.size() != 0 || iq0.size() != 0 || iq1.size() != 0 || iq2.size() != 0);
    repeat (2) @(posedge clk);
    #2;
    check(!out_valid, 7, "idle after drain out_valid", int'(out_valid), 0);  // R7
  endtask

  // driver of inputs and scoreboard monitor
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      cyc++;
      in_valid[0] = iq0.size() != 0;
      in_valid[1] = iq1.size() != 0;
      in_valid[2] = iq2.size() != 0;
      if (iq0.size() != 0) begin in_data[0] = iq0[0].d; in_last[0] = iq0[0].l; in_press[0] = iq0[0].p; end
      if (iq1.size() != 0) begin in_data[1] = iq1[0].d; in_last[1] = iq1[0].l; in_press[1] = iq1[0].p; end
      if (iq2.size() != 0) begin in_data[2] = iq2[0].d; in_last[2] = iq2[0].l; in_press[2] = iq2[0].p; end
      out_ready = !(stall_en && ((cyc % 5 == 1) || (cyc % 5 == 2)));
      #1;
      if (rst_n) begin
        if (gap_chk) check(!out_valid, 7, "out_valid cycle after last", int'(out_valid), 0);  // R7
        gap_chk = 1'b0;
        if (out_valid && sb.size() == 0)
          check(1'b0, 2, "unexpected cell", int'(out_data), 0);  // R2
        else if (out_valid && out_ready) begin
          e = sb.pop_front();
          check(out_data == e.d, e.rq, "out_data", int'(out_data), int'(e.d));
          check(out_src == e.s, e.rq, "out_src", int'(out_src), int'(e.s));
          check(out_last == e.l, 2, "out_last", int'(out_last), int'(e.l));  // R2
          check(out_press == e.p, 5, "out_press", int'(out_press), int'(e.p));  // R5
          if (out_last) gap_chk = 1'b1;
        end
        if (in_valid[0] && in_ready[0]) void'(iq0.pop_front());
        if (in_valid[1] && in_ready[1]) void'(iq1.pop_front());
        if (in_valid[2] && in_ready[2]) void'(iq2.pop_front());
      end
    end
  end

  initial begin
    #(8 * 60000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: cells offered during reset are not taken
    add_pkt(1, 1, 0, 3, 0, 0);
    exp_pkt(1, 1, 0, 3, 0, 2);  // R2 single packet
    repeat (3) @(posedge clk);
    #2;
    check(!out_valid, 1, "out_valid in reset", int'(out_valid), 0);  // R1
    check(in_ready == '0, 1, "in_ready in reset", int'(in_ready), 0);  // R1
    rst_n = 1'b1;
    drain();

    // R3: pressure ranking 1,3,2 on inputs 0,1,2
    add_pkt(0, 2, 0, 2, 1, 0);
    add_pkt(1, 3, 0, 3, 3, 0);
    add_pkt(2, 4, 0, 4, 2, 0);
    exp_pkt(1, 3, 0, 3, 3, 3);
    exp_pkt(2, 4, 0, 4, 2, 3);
    exp_pkt(0, 2, 0, 2, 1, 3);
    drain();

    // R4: equal pressure, previous winner 0, inputs 0 and 2 -> 2 first
    add_pkt(0, 5, 0, 2, 1, 1);
    add_pkt(2, 6, 0, 3, 1, 1);
    exp_pkt(2, 6, 0, 3, 1, 4);
    exp_pkt(0, 5, 0, 2, 1, 4);
    drain();

    // R4 and R6: all equal under output stalls
    stall_en = 1'b1;
    add_pkt(0, 7, 1, 3, 2, 0);
    add_pkt(1, 8, 0, 4, 2, 3);
    add_pkt(2, 9, 0, 2, 2, 1);
    exp_pkt(1, 8, 0, 4, 2, 6);
    exp_pkt(2, 9, 0, 2, 2, 6);
    exp_pkt(0, 7, 1, 3, 2, 4);
    drain();
    stall_en = 1'b0;

    // R5: body sideband differs, late higher pressure does not preempt
    add_pkt(0, 10, 0, 5, 0, 3);
    exp_pkt(0, 10, 0, 5, 0, 5);
    repeat (2) @(posedge clk);
    #2;
    add_pkt(1, 11, 0, 2, 3, 0);
    exp_pkt(1, 11, 0, 2, 3, 5);
    drain();

    // R8, R9: input 0 locks, reads, writes; others wait despite higher pressure
    add_pkt(0, 12, 2, 2, 0, 0);
    add_pkt(0, 13, 0, 2, 0, 0);
    add_pkt(0, 14, 1, 3, 0, 0);
    exp_pkt(0, 12, 2, 2, 0, 8);
    exp_pkt(0, 13, 0, 2, 0, 9);
    exp_pkt(0, 14, 1, 3, 0, 8);
    repeat (2) @(posedge clk);
    #2;
    add_pkt(1, 15, 0, 2, 3, 0);
    add_pkt(2, 16, 0, 2, 2, 0);
    exp_pkt(1, 15, 0, 2, 3, 9);
    exp_pkt(2, 16, 0, 2, 2, 9);
    drain();

    // R9 with non-posted write release, single-cell lock, stalls (R6)
    stall_en = 1'b1;
    add_pkt(2, 17, 2, 1, 0, 0);
    add_pkt(2, 18, 3, 2, 0, 0);
    exp_pkt(2, 17, 2, 1, 0, 8);
    exp_pkt(2, 18, 3, 2, 0, 9);
    repeat (2) @(posedge clk);
    #2;
    add_pkt(0, 19, 0, 2, 3, 0);
    add_pkt(1, 20, 0, 2, 3, 0);
    exp_pkt(0, 19, 0, 2, 3, 4);
    exp_pkt(1, 20, 0, 2, 3, 9);
    drain();
    stall_en = 1'b0;

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule